// File: doc/BRIEF.md
# Add-Compare-Select Datapath with Fixed-Constant Rescaling

This block is the middle pipeline stage of a sixteen-state Viterbi decoder for a rate-1/2 convolutional code with constraint length 5. Each qualified input cycle carries one pair of 3-bit soft symbols. A small front end turns the pair into four branch metrics. Eight butterflies then add, compare and select in parallel to update all sixteen path metrics. The block registers the updated metrics together with a 16-bit vector of survivor decision bits for the survivor memory stage that follows it.

Path metrics are unsigned and 8 bits wide. The block has no circuit that searches for the smallest metric. Instead, a detector watches the top bit of every stored metric. Once all sixteen have reached the upper half of the range, the next qualified update subtracts the same constant, 128, from every new metric. The branch metrics are bounded so that the spread between any two path metrics stays well under 128. The subtraction therefore never wraps, and the ordering between states is kept. Downstream decoding can start from any state, so the block produces no best-state index.

Top module: `acs_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, state 0 holds metric 0, states 1 to 15 hold metric 32, dec_o is 0 and dec_valid_o is 0. The metric of state s appears on pm_o bits [8s+7:8s].
- R2: A soft symbol value y runs from 0 (confident 0) to 7 (confident 1). A code bit expected as 0 costs y and one expected as 1 costs 7-y. The branch metric of a transition is the sum of its two code-bit costs, with sym0_i paired with the first code bit and sym1_i with the second.
- R3: State s is a 4-bit value. An input bit u taken from state s leads to next state {u, s[3:1]}. The encoder word is {u, s[3], s[2], s[1], s[0]}. The first code bit is the parity of that word ANDed with 5'b10011, and the second is the parity of the word ANDed with 5'b11101.
- R4: On a rising edge with valid_i high, next state n receives the smaller of two candidates, each being a predecessor metric plus its branch metric. The two predecessors are 2*(n mod 8) (even) and 2*(n mod 8)+1 (odd). Bit n of dec_o becomes 1 when the odd predecessor is chosen and 0 when the even one is chosen.
- R5: When the two candidates of a state are equal, the even predecessor is chosen and its dec_o bit is 0.
- R6: On a rising edge with valid_i low, every path metric and dec_o keep their values, whatever the symbol inputs carry. dec_valid_o equals the valid_i sampled at the previous rising edge.
- R7: If every stored metric is 128 or more when a valid update is taken, 128 is subtracted from every new metric. If valid_i is low at that edge, the subtraction waits for the next valid update. Over any symbol sequence no metric wraps around, so all metrics keep tracking their true relative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies the symbol pair for this cycle |
| sym0_i | input | 3 | Soft value of the first code bit |
| sym1_i | input | 3 | Soft value of the second code bit |
| dec_o | output | 16 | Survivor decision bit per state, registered |
| dec_valid_o | output | 1 | dec_o and pm_o were updated at the last edge |
| pm_o | output | 128 | Registered path metrics, 8 bits per state |

## Verification
Rescaling and holding can fall in the same cycle: the detector can flag an overflow on an edge where valid_i is low. The bench provokes this by driving a steady symbol pair until its own model sees all sixteen metrics at 128 or above, then holding valid_i low for one cycle before resuming. It judges the outcome on pm_o: the hold cycle must leave every metric untouched, the next valid update must show exactly the 128 drop against the model, and no top bit may remain set afterwards. A tie between the two candidates at the same update is also checked, by a hand-computed state after the very first symbol.

// File: rtl/acs_pkg.sv
package acs_pkg;

  // parity of the encoder word {u, state} masked by generator g
  function automatic logic code_bit(input logic u, input int unsigned st,
                                    input int unsigned g, input int unsigned mem);
    logic [31:0] w;
    w = (32'(u) << mem) | 32'(st);
    return ^(w & 32'(g));
  endfunction

  // {second, first} code bit, used as a branch-metric index
  function automatic logic [1:0] code_pair(input logic u, input int unsigned st,
                                           input int unsigned ga, input int unsigned gb,
                                           input int unsigned mem);
    return {code_bit(u, st, gb, mem), code_bit(u, st, ga, mem)};
  endfunction

endpackage

// File: rtl/acs_bmu.sv
module acs_bmu #(
  parameter int unsigned SOFT_W = 3,
  localparam int unsigned BM_W  = SOFT_W + 1
) (
  input  logic [SOFT_W-1:0]      sym0_i,
  input  logic [SOFT_W-1:0]      sym1_i,
  output logic [3:0][BM_W-1:0]   bm_o
);
  localparam logic [SOFT_W-1:0] SMAX = {SOFT_W{1'b1}};

  for (genvar c = 0; c < 4; c++) begin : g_pair
    logic [SOFT_W-1:0] cost0, cost1;
    assign cost0   = c[0] ? (SMAX - sym0_i) : sym0_i;
    assign cost1   = c[1] ? (SMAX - sym1_i) : sym1_i;
    assign bm_o[c] = BM_W'(cost0) + BM_W'(cost1);
  end
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly
  import acs_pkg::*;
#(
  parameter int unsigned PM_W = 8,
  parameter int unsigned BM_W = 4,
  parameter int unsigned MEM  = 4,
  parameter int unsigned GA   = 32'o23,
  parameter int unsigned GB   = 32'o35,
  parameter int unsigned IDX  = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PM_W-1:0]       pm_even_i,
  input  logic [PM_W-1:0]       pm_odd_i,
  input  logic [3:0][BM_W-1:0]  bm_i,
  input  logic                  rescale_i,
  output logic [1:0][PM_W-1:0]  pm_o,   // [0]: state IDX, [1]: state IDX+half
  output logic [1:0]            dec_o
);
  localparam int unsigned SW = PM_W + 1;
  localparam logic [SW-1:0] RC = SW'(1) << (PM_W - 1);

  for (genvar u = 0; u < 2; u++) begin : g_half
    localparam logic [1:0] CE = code_pair(1'(u), 2 * IDX,     GA, GB, MEM);
    localparam logic [1:0] CO = code_pair(1'(u), 2 * IDX + 1, GA, GB, MEM);

    logic [SW-1:0] sum_e, sum_o, win, nxt;
    logic          pick_odd;

    assign sum_e    = SW'(pm_even_i) + SW'(bm_i[CE]);
    assign sum_o    = SW'(pm_odd_i)  + SW'(bm_i[CO]);
    assign pick_odd = sum_o < sum_e;  // tie keeps even predecessor
    assign win      = pick_odd ? sum_o : sum_e;
    assign nxt      = win - (rescale_i ? RC : '0);
    assign pm_o[u]  = nxt[PM_W-1:0];
    assign dec_o[u] = pick_odd;

    // R7
    no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sum_e[PM_W] && !sum_o[PM_W]);
    // R7
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rescale_i |-> (win >= RC));
  end
endmodule

// File: rtl/acs_unit.sv
module acs_unit
  import acs_pkg::*;
#(
  parameter int unsigned CONSTR_LEN = 5,
  parameter int unsigned SOFT_W     = 3,
  parameter int unsigned PM_W       = 8,
  parameter int unsigned GEN_A      = 32'o23,
  parameter int unsigned GEN_B      = 32'o35,
  parameter int unsigned INIT_BIAS  = 32,
  localparam int unsigned MEM  = CONSTR_LEN - 1,
  localparam int unsigned NS   = 1 << MEM,
  localparam int unsigned HALF = NS / 2,
  localparam int unsigned BM_W = SOFT_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [SOFT_W-1:0]  sym0_i,
  input  logic [SOFT_W-1:0]  sym1_i,
  output logic [NS-1:0]      dec_o,
  output logic               dec_valid_o,
  output logic [NS*PM_W-1:0] pm_o
);
  logic [3:0][BM_W-1:0]  bm;
  logic [NS-1:0][PM_W-1:0] pm_q, pm_d;
  logic [NS-1:0]         dec_d, msb;
  logic                  ovf;

  acs_bmu #(.SOFT_W(SOFT_W)) u_bmu (
    .sym0_i (sym0_i),
    .sym1_i (sym1_i),
    .bm_o   (bm)
  );

  // overflow detector: all metrics in upper half
  always_comb begin
    for (int s = 0; s < NS; s++) msb[s] = pm_q[s][PM_W-1];
  end
  assign ovf = &msb;

  for (genvar j = 0; j < HALF; j++) begin : g_bfly
    logic [1:0][PM_W-1:0] bpm;
    logic [1:0]           bdec;

    acs_butterfly #(
      .PM_W (PM_W), .BM_W (BM_W), .MEM (MEM),
      .GA   (GEN_A), .GB (GEN_B), .IDX (j)
    ) u_bfly (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pm_even_i (pm_q[2*j]),
      .pm_odd_i  (pm_q[2*j+1]),
      .bm_i      (bm),
      .rescale_i (ovf),
      .pm_o      (bpm),
      .dec_o     (bdec)
    );

    assign pm_d[j]       = bpm[0];
    assign pm_d[j+HALF]  = bpm[1];
    assign dec_d[j]      = bdec[0];
    assign dec_d[j+HALF] = bdec[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NS; s++) pm_q[s] <= (s == 0) ? '0 : PM_W'(INIT_BIAS);
      dec_o       <= '0;
      dec_valid_o <= 1'b0;
    end else begin
      dec_valid_o <= valid_i;
      if (valid_i) begin
        pm_q  <= pm_d;
        dec_o <= dec_d;
      end
    end
  end

  assign pm_o = pm_q;

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pm_o) && $stable(dec_o)));
  // R6
  dvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> dec_valid_o);
  // R6
  dvalid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !dec_valid_o);
  // R7
  rescale_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ovf) |=> (pm_o[PM_W-1:0] < $past(pm_o[PM_W-1:0])));
endmodule

// File: tb/acs_unit_tb.sv
module acs_unit_tb;
  localparam int NS = 16;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [2:0]      sym0_i = '0, sym1_i = '0;
  logic [NS-1:0]   dec_o;
  logic            dec_valid_o;
  logic [NS*PW-1:0] pm_o;

  int checks = 0, fails = 0;
  int mdl[NS];
  logic [NS-1:0] mdec;
  bit  last_rescale;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  acs_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .sym0_i(sym0_i), .sym1_i(sym1_i),
    .dec_o(dec_o), .dec_valid_o(dec_valid_o), .pm_o(pm_o)
  );

  function automatic int par(input int v);
    int p = 0;
    for (int i = 0; i < 32; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  function automatic int cost(input int c, input int y);
    return c ? (7 - y) : y;
  endfunction

  function automatic int bmet(input int u, input int s, input int y0, input int y1);
    int w = (u << 4) | s;
    return cost(par(w & 'o23), y0) + cost(par(w & 'o35), y1);
  endfunction

  function automatic logic [NS*PW-1:0] exp_bus();
    logic [NS*PW-1:0] b;
    for (int s = 0; s < NS; s++) b[s*PW +: PW] = PW'(mdl[s]);
    return b;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NS; s++) mdl[s] = (s == 0) ? 0 : 32;
    mdec = '0;
  endtask

  task automatic model_step(input int y0, input int y1);
    int nx[NS];
    bit all_hi = 1'b1;
    for (int s = 0; s < NS; s++) if (mdl[s] < 128) all_hi = 1'b0;
    last_rescale = all_hi;
    for (int n = 0; n < NS; n++) begin
      int u = n >> 3, pe = 2 * (n & 7), po = pe + 1;
      int a = mdl[pe] + bmet(u, pe, y0, y1);
      int b = mdl[po] + bmet(u, po, y0, y1);
      mdec[n] = (b < a);
      nx[n] = ((b < a) ? b : a) - (all_hi ? 128 : 0);
    end
    for (int s = 0; s < NS; s++) mdl[s] = nx[s];
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NS*PW-1:0] act, input logic [NS*PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  // drive at negedge, registered result visible at the next negedge
  task automatic step(input int y0, input int y1, input bit vld, input string req);
    valid_i = vld; sym0_i = 3'(y0); sym1_i = 3'(y1);
    if (vld) model_step(y0, y1);
    @(posedge clk); @(negedge clk);
    chk(pm_o === exp_bus(), req, "pm", pm_o, exp_bus());
    chk(dec_o === mdec, req, "dec", 128'(dec_o), 128'(mdec));
    chk(dec_valid_o === vld, "R6", "dec_valid", 128'(dec_valid_o), 128'(vld));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    model_reset();
    chk(pm_o === exp_bus(), "R1", "pm in reset", pm_o, exp_bus());
    do_reset();
    chk(pm_o === exp_bus(), "R1", "pm after reset", pm_o, exp_bus());
    chk(dec_o === '0 && dec_valid_o === 1'b0, "R1", "dec after reset",
        128'({dec_valid_o, dec_o}), 128'(0));
  endtask

  task automatic t_first_symbol();
    do_reset();
    step(0, 0, 1'b1, "R3");
    chk(pm_o[0 +: PW] === 8'd0,  "R3", "state0", 128'(pm_o[0 +: PW]), 128'd0);
    chk(pm_o[8*PW +: PW] === 8'd14, "R3", "state8", 128'(pm_o[8*PW +: PW]), 128'd14);
    // R5: state1 preds 2 and 3 both give 39
    chk(pm_o[PW +: PW] === 8'd39 && dec_o[1] === 1'b0, "R5", "tie state1",
        128'({dec_o[1], pm_o[PW +: PW]}), 128'({1'b0, 8'd39}));
  endtask

  task automatic t_inverted_cost();
    do_reset();
    step(7, 7, 1'b1, "R2");
    chk(pm_o[8*PW +: PW] === 8'd0, "R2", "state8", 128'(pm_o[8*PW +: PW]), 128'd0);
    chk(pm_o[0 +: PW] === 8'd14, "R2", "state0", 128'(pm_o[0 +: PW]), 128'd14);
  endtask

  task automatic t_random(input int n);
    do_reset();
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[2:0]), int'(lfsr[6:4]), 1'b1, "R4");
    end
  endtask

  task automatic t_hold();
    step(1, 6, 1'b1, "R4");
    step(7, 0, 1'b0, "R6");
    step(3, 3, 1'b0, "R6");
    step(2, 5, 1'b1, "R4");
  endtask

  task automatic t_rescale_hold();
    bit hi;
    int guard = 0;
    do_reset();
    do begin
      step(3, 4, 1'b1, "R7");
      hi = 1'b1;
      for (int s = 0; s < NS; s++) if (mdl[s] < 128) hi = 1'b0;
      guard++;
    end while (!hi && guard < 100);
    chk(hi, "R7", "overflow reached", 128'(hi), 128'(1));
    step(0, 7, 1'b0, "R7");  // flagged but not valid: hold
    step(3, 4, 1'b1, "R7");
    chk(last_rescale, "R7", "rescale applied", 128'(last_rescale), 128'(1));
    begin
      logic [NS-1:0] tops;
      for (int s = 0; s < NS; s++) tops[s] = pm_o[s*PW + PW - 1];
      chk(tops === '0, "R7", "msb after rescale", 128'(tops), 128'(0));
    end
    for (int i = 0; i < 60; i++) step(i % 8, (i * 3) % 8, 1'b1, "R7");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_symbol();
    t_inverted_cost();
    t_random(150);
    t_hold();
    t_rescale_hold();
    t_random(300);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule